// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block brings up a target FPGA that takes its bitstream over a two-wire passive serial link. On a start request it pulses the active-low configuration request `cfg_n`, and it expects the target to answer by pulling the active-low status line `stat_n` low. It then releases the request and polls `stat_n` in fixed slices until the target signals readiness. After a profile-dependent settling gap it serializes the bitstream bytes it takes from a valid/ready stream onto `dout`, with a generated clock `dclk`. When the last byte has gone out it checks `stat_n` and, if enabled, the done input. On a clean check it sends one more byte of clocks so that the target can start its initialization.

All delays are given in microseconds and are turned into cycles by `CYC_PER_US`. `profile_sel` picks one of two timing profiles. Profile 0 has a 1506 µs status window and a 2 µs gap before the first clock. Profile 1 has a 3000 µs window and a 10 µs gap. This input, `lsb_first` and `done_chk_en` are captured at start and hold for the whole load.

The controller has these states: IDLE, PULSE (request held low), POLL (status sampled once per slice), GAP (status-to-clock delay), WAIT_BYTE (stream ready), SHIFT (byte on the wire), END_CHK, TAIL (dummy byte), DONE and FAIL. The transitions are:
- start: IDLE, DONE or FAIL to PULSE, or to FAIL on a partial request.
- pulse_ok: PULSE to POLL. pulse_bad: PULSE to FAIL.
- ready: POLL to GAP. next_slice: POLL to POLL. timeout: POLL to FAIL.
- gap_over: GAP to WAIT_BYTE.
- take_byte: WAIT_BYTE to SHIFT.
- byte_sent: SHIFT to WAIT_BYTE, or to END_CHK after the byte marked last.
- end_ok: END_CHK to TAIL. end_bad: END_CHK to FAIL.
- tail_sent: TAIL to DONE.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, `cfg_n`=1, `dclk`=0, `busy`=0, `done`=0 and `err`=0.
- R2: A start with `partial_req`=0 drives `cfg_n` low for T_CFG_US·CYC_PER_US cycles. If `stat_n` is still high at the end of the pulse, `err` becomes 2, `busy` drops and `cfg_n` stays low.
- R3: When the pulse succeeds, `cfg_n` returns high and `stat_n` is sampled at the end of each slice of T_STAT_US µs. There are ceil(max/T_STAT_US) slices: 6 for profile 0 and 12 for profile 1. If `stat_n` is never seen high, `err` becomes 3 exactly slices·slice-length cycles after `cfg_n` rose.
- R4: `dclk` stays low until the data phase. The first rising edge of `dclk` comes no earlier than 2 µs (profile 0) or 10 µs (profile 1) after `stat_n` went high, and within one slice plus that gap.
- R5: Each byte is sent as 8 bits. With `lsb_first`=1, bit 0 goes out first. With `lsb_first`=0, the byte is reversed and bit 7 goes out first.
- R6: `dclk` stays high for DIV cycles per bit. `dout` changes only while `dclk` is low, so it is stable across each rising edge.
- R7: `s_ready` is high only while the block can take a byte. Any length of one or more bytes is accepted, including lengths that are not a multiple of four. The byte sent with `s_last`=1 ends the data.
- R8: If `stat_n` is low when the data ends, `err` becomes 4 and no tail clocks are sent.
- R9: With `done_chk_en`=1 and `conf_done`=0 when the data ends, `err` becomes 5 and no tail clocks are sent. With `done_chk_en`=0, `conf_done` has no effect.
- R10: After a clean end check, the block sends 8 more `dclk` periods with `dout`=0. It then shows `done`=1, `busy`=0 and `err`=0.
- R11: A start with `partial_req`=1 sets `err` to 1 on the next cycle. It leaves `cfg_n` unchanged and issues no `dclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle load request |
| partial_req | input | 1 | Request is a partial reconfiguration (rejected) |
| profile_sel | input | 1 | Timing profile: 0 = short window, 1 = long window |
| lsb_first | input | 1 | 1 = bytes already LSB-first, 0 = reverse each byte |
| done_chk_en | input | 1 | Check `conf_done` at the end of the data |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final bitstream byte |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| cfg_n | output | 1 | Active-low configuration request to the target |
| stat_n | input | 1 | Active-low status from the target |
| conf_done | input | 1 | Configuration-done from the target |
| dclk | output | 1 | Generated serial clock |
| dout | output | 1 | Serial data |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load finished cleanly |
| err | output | 3 | 0 none, 1 partial, 2 no reset seen, 3 status timeout, 4 status fault at end, 5 done missing |

## Verification
A slice counter that is off by one shows up at the ports as a timeout that arrives one slice length (hundreds of cycles) early or late. A wrong gap or profile capture moves the first `dclk` rise relative to the `stat_n` release, and this is visible on the first data bit. A mistake in bit order or in the shifter state corrupts the serial stream within the first byte. A bad end check either sends tail clocks it should suppress or reports the wrong code, and this is visible as soon as `busy` falls.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_POLL,
        ST_GAP,
        ST_WAIT_BYTE,
        ST_SHIFT,
        ST_END_CHK,
        ST_TAIL,
        ST_DONE,
        ST_FAIL
    } ld_state_e;

    typedef enum logic [2:0] {
        E_NONE      = 3'd0,
        E_PARTIAL   = 3'd1,
        E_NO_RESET  = 3'd2,
        E_NOT_READY = 3'd3,
        E_CFG_FAULT = 3'd4,
        E_NO_DONE   = 3'd5
    } ld_err_e;

endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         fire
);
    logic [W-1:0] cnt;
    logic         run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= len;
            run <= 1'b1;
        end else if (run) begin
            cnt <= cnt - 1'b1;
            if (cnt == W'(1)) run <= 1'b0;
        end
    end

    assign fire = run && (cnt == W'(1));

    // R3: a zero-length wait would never fire
    a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0));
endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    output logic       sh_busy,
    output logic       dclk,
    output logic       dout
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] ph;
    logic [2:0]    idx;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= '0;
            idx     <= '0;
            sh      <= '0;
            sh_busy <= 1'b0;
            dclk    <= 1'b0;
            dout    <= 1'b0;
        end else if (load && !sh_busy) begin
            sh      <= din;
            dout    <= din[0];
            idx     <= '0;
            ph      <= '0;
            sh_busy <= 1'b1;
            dclk    <= 1'b0;
        end else if (sh_busy) begin
            if (ph == CW'(DIV - 1)) begin
                ph <= '0;
                if (!dclk) begin
                    dclk <= 1'b1;
                end else begin
                    dclk <= 1'b0;
                    if (idx == 3'd7) begin
                        sh_busy <= 1'b0;
                    end else begin
                        idx  <= idx + 1'b1;
                        sh   <= sh >> 1;
                        dout <= sh[1];
                    end
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    // R6: data held across the whole high phase
    a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk && $past(dclk)) |-> $stable(dout));
    a_r6_clock_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk) |-> sh_busy);
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
    import ps_cfg_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int DIV        = 4,
    parameter int T_CFG_US   = 2,
    parameter int T_STAT_US  = 268,
    parameter int T_MAX0_US  = 1506,
    parameter int T_MAX1_US  = 3000,
    parameter int T_GAP0_US  = 2,
    parameter int T_GAP1_US  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       partial_req,
    input  logic       profile_sel,
    input  logic       lsb_first,
    input  logic       done_chk_en,
    input  logic       s_valid,
    input  logic [7:0] s_data,
    input  logic       s_last,
    output logic       s_ready,
    output logic       cfg_n,
    input  logic       stat_n,
    input  logic       conf_done,
    output logic       dclk,
    output logic       dout,
    output logic       busy,
    output logic       done,
    output logic [2:0] err
);
    localparam int SLICES0 = (T_MAX0_US + T_STAT_US - 1) / T_STAT_US;
    localparam int SLICES1 = (T_MAX1_US + T_STAT_US - 1) / T_STAT_US;
    localparam int SMAX    = (SLICES0 > SLICES1) ? SLICES0 : SLICES1;
    localparam int SLW     = $clog2(SMAX + 1);
    localparam int GMAX    = (T_GAP0_US > T_GAP1_US) ? T_GAP0_US : T_GAP1_US;
    localparam int UMAX1   = (T_STAT_US > GMAX) ? T_STAT_US : GMAX;
    localparam int UMAX    = (UMAX1 > T_CFG_US) ? UMAX1 : T_CFG_US;
    localparam int TW      = $clog2(UMAX * CYC_PER_US + 1);
    localparam logic [TW-1:0] L_CFG   = TW'(T_CFG_US * CYC_PER_US);
    localparam logic [TW-1:0] L_SLICE = TW'(T_STAT_US * CYC_PER_US);
    localparam logic [TW-1:0] L_GAP0  = TW'(T_GAP0_US * CYC_PER_US);
    localparam logic [TW-1:0] L_GAP1  = TW'(T_GAP1_US * CYC_PER_US);

    ld_state_e      st, st_nx;
    ld_err_e        err_q;
    logic           cfgn_q, prof_q, lsb_q, dchk_q, last_q;
    logic [SLW-1:0] slice_q, last_slice;
    logic           tmr_load, fire, sh_load, sh_busy;
    logic [TW-1:0]  tmr_len;
    logic [7:0]     sh_byte;

    function automatic logic [7:0] flip8(input logic [7:0] b);
        for (int i = 0; i < 8; i++) flip8[i] = b[7 - i];
    endfunction

    assign last_slice = prof_q ? SLW'(SLICES1 - 1) : SLW'(SLICES0 - 1);

    ps_cfg_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .fire(fire)
    );

    ps_cfg_shifter #(.DIV(DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .din(sh_byte),
        .sh_busy(sh_busy), .dclk(dclk), .dout(dout)
    );

    // next-state and strobes
    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_len  = L_SLICE;
        sh_load  = 1'b0;
        sh_byte  = 8'h00;
        unique case (st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    if (partial_req) begin
                        st_nx = ST_FAIL;
                    end else begin
                        st_nx    = ST_PULSE;
                        tmr_load = 1'b1;
                        tmr_len  = L_CFG;
                    end
                end
            end
            ST_PULSE: begin
                if (fire) begin
                    if (stat_n) begin
                        st_nx = ST_FAIL;
                    end else begin
                        st_nx    = ST_POLL;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_POLL: begin
                if (fire) begin
                    if (stat_n) begin
                        st_nx    = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_len  = prof_q ? L_GAP1 : L_GAP0;
                    end else if (slice_q == last_slice) begin
                        st_nx = ST_FAIL;
                    end else begin
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_GAP:       if (fire) st_nx = ST_WAIT_BYTE;
            ST_WAIT_BYTE: begin
                if (s_valid) begin
                    st_nx   = ST_SHIFT;
                    sh_load = 1'b1;
                    sh_byte = lsb_q ? s_data : flip8(s_data);
                end
            end
            ST_SHIFT:     if (!sh_busy) st_nx = last_q ? ST_END_CHK : ST_WAIT_BYTE;
            ST_END_CHK: begin
                if (!stat_n || (dchk_q && !conf_done)) begin
                    st_nx = ST_FAIL;
                end else begin
                    st_nx   = ST_TAIL;
                    sh_load = 1'b1;
                end
            end
            ST_TAIL:      if (!sh_busy) st_nx = ST_DONE;
            default:      st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // registered outputs and load context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfgn_q  <= 1'b1;
            err_q   <= E_NONE;
            prof_q  <= 1'b0;
            lsb_q   <= 1'b0;
            dchk_q  <= 1'b0;
            last_q  <= 1'b0;
            slice_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        if (partial_req) begin
                            err_q <= E_PARTIAL;
                        end else begin
                            err_q  <= E_NONE;
                            cfgn_q <= 1'b0;
                            prof_q <= profile_sel;
                            lsb_q  <= lsb_first;
                            dchk_q <= done_chk_en;
                        end
                    end
                end
                ST_PULSE: begin
                    if (fire) begin
                        if (stat_n) begin
                            err_q <= E_NO_RESET;
                        end else begin
                            cfgn_q  <= 1'b1;
                            slice_q <= '0;
                        end
                    end
                end
                ST_POLL: begin
                    if (fire && !stat_n) begin
                        if (slice_q == last_slice) err_q <= E_NOT_READY;
                        slice_q <= slice_q + 1'b1;
                    end
                end
                ST_WAIT_BYTE: if (s_valid) last_q <= s_last;
                ST_END_CHK: begin
                    if (!stat_n)                   err_q <= E_CFG_FAULT;
                    else if (dchk_q && !conf_done) err_q <= E_NO_DONE;
                end
                default: ;
            endcase
        end
    end

    assign cfg_n   = cfgn_q;
    assign err     = err_q;
    assign s_ready = (st == ST_WAIT_BYTE);
    assign done    = (st == ST_DONE);
    assign busy    = !(st inside {ST_IDLE, ST_DONE, ST_FAIL});

    // R4: no clock outside the data and tail phases
    a_r4_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {ST_IDLE, ST_PULSE, ST_POLL, ST_GAP, ST_END_CHK, ST_DONE, ST_FAIL}) |-> !dclk);
    // R2: request stays low during the pulse
    a_r2_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PULSE) |-> !cfg_n);
    // R11: a partial request touches no pin
    a_r11_partial_hands_off: assert property (@(posedge clk) disable iff (!rst_n)
        ((st inside {ST_IDLE, ST_DONE, ST_FAIL}) && start && partial_req)
        |=> ($stable(cfg_n) && err == 3'd1 && !dclk));
    // R7: a byte is only taken when the serializer is free
    a_r7_ready_free: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (!sh_busy && !dclk));
    // R10: clean completion carries no error
    a_r10_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == 3'd0 && !busy && cfg_n));
    // R3: a timeout leaves the request released
    a_r3_timeout_released: assert property (@(posedge clk) disable iff (!rst_n)
        (err == 3'd3) |-> cfg_n);
endmodule

// File: tb/ps_cfg_loader_bench.sv
`timescale 1ns/1ps
module ps_cfg_loader_bench;
    localparam int CYC   = 2;
    localparam int DIV   = 2;
    localparam int SLICE = 268 * CYC;
    localparam int SL0   = 6;
    localparam int SL1   = 12;
    localparam int PCFG  = 2 * CYC;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       start = 0, partial_req = 0, profile_sel = 0, lsb_first = 0, done_chk_en = 0;
    logic       s_valid = 0, s_last = 0;
    logic [7:0] s_data = 8'h00;
    logic       s_ready, cfg_n, dclk, dout, busy, done;
    logic       stat_n = 1'b1, conf_done = 1'b1;
    logic [2:0] err;

    ps_cfg_loader #(.CYC_PER_US(CYC), .DIV(DIV)) u_ps_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial_req),
        .profile_sel(profile_sel), .lsb_first(lsb_first), .done_chk_en(done_chk_en),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .cfg_n(cfg_n), .stat_n(stat_n), .conf_done(conf_done),
        .dclk(dclk), .dout(dout), .busy(busy), .done(done), .err(err)
    );

    always #4 clk = ~clk;

    int ntests = 0, nfail = 0;
    int cyc = 0;
    int ncap = 0, nfall_cfg = 0;
    logic cap [0:4095];
    int t_cfg_fall = 0, t_cfg_rise = 0, t_stat_rise = 0, t_first = 0;
    bit first_pending = 0;
    int hrun = 0, bad_hi = 0, bad_dat = 0;
    logic pdclk = 0, pdout = 0;
    bit tgt_present = 1, tgt_stuck = 0, tgt_fault = 0;
    int rel_delay = 20, rel_cnt = 0;
    logic [7:0] dat [0:31];
    int unsigned seed_dummy;

    always @(posedge clk) cyc++;

    // target model
    always @(negedge clk) begin
        if (tgt_fault) stat_n <= 1'b0;
        else if (!cfg_n) begin
            stat_n  <= !tgt_present;
            rel_cnt <= 0;
        end else if (!stat_n) begin
            if (!tgt_stuck && rel_cnt >= rel_delay) begin
                stat_n      <= 1'b1;
                t_stat_rise <= cyc;
            end else rel_cnt <= rel_cnt + 1;
        end
    end

    // serial capture and waveform monitors
    always @(posedge dclk) begin
        if (ncap < 4096) cap[ncap] = dout;
        ncap++;
        if (first_pending) begin t_first = cyc; first_pending = 0; end
    end
    always @(negedge cfg_n) begin t_cfg_fall = cyc; nfall_cfg++; end
    always @(posedge cfg_n) t_cfg_rise = cyc;
    always @(negedge clk) if (rst_n) begin
        if (dclk === 1'b1) hrun++;
        else begin
            if (hrun != 0 && hrun != DIV) bad_hi++;
            hrun = 0;
        end
        if (dclk === 1'b1 && pdclk === 1'b1 && dout !== pdout) bad_dat++;
        pdclk = dclk;
        pdout = dout;
    end

    task automatic check(input string req, input int act, input int exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        ntests++;
        if (act < lo || act > hi) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic do_start(input bit prof, input bit lsb, input bit dchk, input bit part);
        @(negedge clk);
        profile_sel = prof; lsb_first = lsb; done_chk_en = dchk; partial_req = part;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; partial_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
    endtask

    task automatic send_bytes(input int n, input int fault_at);
        for (int i = 0; i < n; i++) begin
            if (i == fault_at) tgt_fault = 1;
            if (int'($urandom % 4) == 0) begin
                s_valid = 1'b0;
                repeat (int'($urandom % 3) + 1) @(negedge clk);
            end
            s_valid = 1'b1; s_data = dat[i]; s_last = (i == n - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    function automatic int bit_errors(input int base, input int n, input bit lsb, input bit tail);
        int m = 0;
        logic eb;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < 8; j++) begin
                eb = lsb ? dat[i][j] : dat[i][7 - j];
                if (cap[base + i * 8 + j] !== eb) m++;
            end
        if (tail)
            for (int j = 0; j < 8; j++)
                if (cap[base + n * 8 + j] !== 1'b0) m++;
        return m;
    endfunction

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) dat[i] = 8'($urandom);
    endtask

    task automatic good_load(input bit prof, input bit lsb, input bit dchk, input int n);
        int base;
        fill(n);
        rel_delay = 10 + int'($urandom % (prof ? 5800 : 2900));
        base = ncap;
        first_pending = 1;
        do_start(prof, lsb, dchk, 0);
        send_bytes(n, -1);
        wait_idle();
        check("R10 err", int'(err), 0);
        check("R10 done", int'(done), 1);
        check("R7 clock count", ncap - base, 8 * (n + 1));
        check("R5 bit errors", bit_errors(base, n, lsb, 1), 0);
        check_range("R2 pulse width", t_cfg_rise - t_cfg_fall, PCFG, PCFG + 1);
        check_range("R4 gap", t_first - t_stat_rise, (prof ? 10 : 2) * CYC,
                    SLICE + (prof ? 10 : 2) * CYC + 20);
    endtask

    initial begin
        int nf0, base;
        seed_dummy = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 cfg_n", int'(cfg_n), 1);
        check("R1 dclk", int'(dclk), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 err", int'(err), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11: partial request refused
        nf0 = nfall_cfg;
        base = ncap;
        do_start(0, 1, 0, 1);
        check("R11 err", int'(err), 1);
        check("R11 cfg_n", int'(cfg_n), 1);
        repeat (10) @(negedge clk);
        check("R11 no cfg edge", nfall_cfg - nf0, 0);
        check("R11 no dclk", ncap - base, 0);

        // R2: target absent, no reset seen
        tgt_present = 0;
        do_start(0, 1, 0, 0);
        wait_idle();
        check("R2 err", int'(err), 2);
        check("R2 cfg_n held", int'(cfg_n), 0);
        check("R2 busy", int'(busy), 0);
        tgt_present = 1;
        repeat (3) @(negedge clk);

        // R3: status never released, both profiles
        tgt_stuck = 1;
        for (int p = 0; p < 2; p++) begin
            do_start(p[0], 1, 0, 0);
            wait_idle();
            check("R3 err", int'(err), 3);
            check_range("R3 window", cyc - t_cfg_rise, (p ? SL1 : SL0) * SLICE - 1,
                        (p ? SL1 : SL0) * SLICE + 1);
        end
        tgt_stuck = 0;

        // R4 R5 R7 R10: directed lengths then random loads
        good_load(0, 1, 0, 1);
        good_load(1, 0, 1, 4);
        good_load(0, 0, 1, 5);
        good_load(1, 1, 0, 7);
        for (int it = 0; it < 6; it++)
            good_load(1'($urandom), 1'($urandom), 1'($urandom), 1 + int'($urandom % 23));

        // R8: status drops during data
        fill(9);
        rel_delay = 40;
        base = ncap;
        do_start(0, 1, 0, 0);
        send_bytes(9, 4);
        wait_idle();
        check("R8 err", int'(err), 4);
        check("R8 no tail", ncap - base, 72);
        tgt_fault = 0;
        repeat (3) @(negedge clk);

        // R9: done missing, checked and unchecked
        conf_done = 1'b0;
        fill(3);
        base = ncap;
        do_start(1, 1, 1, 0);
        send_bytes(3, -1);
        wait_idle();
        check("R9 err", int'(err), 5);
        check("R9 no tail", ncap - base, 24);
        base = ncap;
        do_start(0, 0, 0, 0);
        send_bytes(3, -1);
        wait_idle();
        check("R9 ignored err", int'(err), 0);
        check("R9 ignored done", int'(done), 1);
        check("R9 ignored clocks", ncap - base, 32);
        conf_done = 1'b1;

        // R6: high phase length and data stability
        check("R6 high phase", bad_hi, 0);
        check("R6 data stable", bad_dat, 0);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        ntests++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule